// File: doc/BRIEF.md
# Time-Multiplexed Interrupt Level Synchronizer

This block gathers thirty-two interrupt request levels that peripherals deliver over only eight shared, active-high request lines. It drives a two-bit slot number that advances on every clock. While slot k is shown, the peripherals whose requests belong to levels 8k through 8k+7 place them on the eight lines. A two-bit scan setting decides how many slots the rotation visits, and so which level groups are ever collected.

The lines are registered once, tagged with the slot they were sampled in, and written into the matching eight-bit group of a 32-bit pending vector on the following clock. That vector is the block's single result. A bus master reads it, and it is also forwarded unchanged to a downstream interrupt controller. Its bit 7 also acts as a summary flag: it reads as set whenever any level from 8 upward is pending.

Top module: `irq_lvl_sync`

## Requirements
- R1: A synchronous active-high reset clears every pending bit and sets the slot output to 0.
- R2: With scan setting 0 the slot output stays at 0, and pending bits 8 to 31 stay clear.
- R3: With scan setting 1 the slot output alternates 0, 1, 0, 1 on successive clocks.
- R4: With scan setting 2 the slot output repeats the sequence 0, 1, 2.
- R5: With scan setting 3 the slot output repeats the sequence 0, 1, 2, 3.
- R6: Request line i sampled while slot k is shown sets or clears pending bit 8k+i. Groups that are not sampled keep their values.
- R7: Line values present in the clock cycle that ends at edge E appear in the pending output after edge E+1, and not after edge E.
- R8: Pending bit 7 reads 1 whenever any pending bit from 8 to 31 is 1. Otherwise it shows its own sampled value.
- R9: On the first clock after the scan setting changes, the slot output returns to 0. Every group with an index above the new setting is cleared on that edge and stays clear.
- R10: Requests are levels and do not stick. A line sampled low clears its pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_mode_i | input | 2 | Highest group index the slot rotation visits |
| req_lines_i | input | 8 | Shared active-high request lines |
| slot_o | output | 2 | Group currently allowed to drive the request lines |
| pend_o | output | 32 | Pending levels, bit n is level n, bit 7 includes the upper-level summary |

## Verification
The bench acts as the peripherals. Each clock it places on the lines the eight bits of a 32-bit source pattern that belong to the slot the block is showing, and it compares slot and pending against a cycle model on every clock. It checks the two-clock delay from the lines to the pending bits, which a design without the input register, or with an extra one, would miss by a cycle. It switches the scan setting from a long rotation to a short one while all levels are requested, and expects an immediate restart at slot 0 and cleared upper groups. A design that let an in-flight sample rewrite a dropped group would show stale upper bits there. It also raises only a level in the top group with bit 7 low, and drops requests to zero, which catches a missing summary OR and pending bits that stick.

// File: rtl/irq_sync_pkg.sv
package irq_sync_pkg;
   localparam int unsigned DEF_LINE_W = 8;
   localparam int unsigned DEF_SEL_W  = 2;

   typedef enum logic [1:0] {
      SCAN_G0   = 2'd0,
      SCAN_G01  = 2'd1,
      SCAN_G012 = 2'd2,
      SCAN_ALL  = 2'd3
   } scan_mode_e;
endpackage

// File: rtl/irq_slot_seq.sv
module irq_slot_seq #(
   parameter int unsigned SEL_W = irq_sync_pkg::DEF_SEL_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] mode_i,
   output logic [SEL_W-1:0] slot_o
);
   logic [SEL_W-1:0] mode_q;
   logic [SEL_W-1:0] slot_q;
   logic             restart;

   assign restart = (mode_i != mode_q) || (slot_q >= mode_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= '0;
         slot_q <= '0;
      end else begin
         mode_q <= mode_i;
         if (restart) slot_q <= '0;
         else         slot_q <= slot_q + 1'b1;
      end
   end

   assign slot_o = slot_q;

   AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (rst)
      (mode_i != mode_q) |=> (slot_q == '0));                              // R9
   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
      (mode_i == mode_q && slot_q < mode_q) |=> (slot_q == $past(slot_q) + 1'b1)); // R5
   AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
      (mode_i == mode_q) |=> (slot_q <= mode_q));                          // R2
endmodule

// File: rtl/irq_line_capture.sv
module irq_line_capture #(
   parameter int unsigned LINE_W = irq_sync_pkg::DEF_LINE_W,
   parameter int unsigned SEL_W  = irq_sync_pkg::DEF_SEL_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [LINE_W-1:0] lines_i,
   input  logic [SEL_W-1:0]  slot_i,
   output logic [LINE_W-1:0] cap_lines_o,
   output logic [SEL_W-1:0]  cap_grp_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cap_lines_o <= '0;
         cap_grp_o   <= '0;
      end else begin
         cap_lines_o <= lines_i;
         cap_grp_o   <= slot_i;
      end
   end

   AST_CAPTURE_TAG: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (cap_grp_o == $past(slot_i)));                              // R6
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned LINE_W = irq_sync_pkg::DEF_LINE_W,
   parameter int unsigned SEL_W  = irq_sync_pkg::DEF_SEL_W
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic [SEL_W-1:0]                mode_i,
   input  logic [LINE_W-1:0]               cap_lines_i,
   input  logic [SEL_W-1:0]                cap_grp_i,
   output logic [(LINE_W<<SEL_W)-1:0]      raw_o
);
   localparam int unsigned GROUPS = 1 << SEL_W;

   logic [LINE_W-1:0] grp_q [GROUPS];

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      localparam logic [SEL_W-1:0] GID = SEL_W'(g);

      always_ff @(posedge clk) begin
         if (rst)                   grp_q[g] <= '0;
         else if (GID > mode_i)     grp_q[g] <= '0;
         else if (cap_grp_i == GID) grp_q[g] <= cap_lines_i;
      end

      assign raw_o[g*LINE_W +: LINE_W] = grp_q[g];

      AST_DROPPED_CLEAR: assert property (@(posedge clk) disable iff (rst)
         (GID > mode_i) |=> (raw_o[g*LINE_W +: LINE_W] == '0));             // R9
      AST_GROUP_WRITE: assert property (@(posedge clk) disable iff (rst)
         (GID <= mode_i && cap_grp_i == GID) |=>
            (raw_o[g*LINE_W +: LINE_W] == $past(cap_lines_i)));             // R6
      AST_GROUP_HOLD: assert property (@(posedge clk) disable iff (rst)
         (GID <= mode_i && cap_grp_i != GID) |=>
            $stable(raw_o[g*LINE_W +: LINE_W]));                            // R6
   end
endmodule

// File: rtl/irq_lvl_sync.sv
module irq_lvl_sync #(
   parameter int unsigned LINE_W = irq_sync_pkg::DEF_LINE_W,
   parameter int unsigned SEL_W  = irq_sync_pkg::DEF_SEL_W
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [SEL_W-1:0]            scan_mode_i,
   input  logic [LINE_W-1:0]           req_lines_i,
   output logic [SEL_W-1:0]            slot_o,
   output logic [(LINE_W<<SEL_W)-1:0]  pend_o
);
   localparam int unsigned LEVELS  = LINE_W << SEL_W;
   localparam int unsigned AGG_BIT = LINE_W - 1;

   if (LINE_W < 1) begin : g_bad_line
      $error("LINE_W must be at least 1");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("SEL_W must lie in 1..4");
   end

   logic [LINE_W-1:0] cap_lines;
   logic [SEL_W-1:0]  cap_grp;
   logic [LEVELS-1:0] raw;

   irq_slot_seq #(.SEL_W(SEL_W)) u_seq (
      .clk    (clk),
      .rst    (rst),
      .mode_i (scan_mode_i),
      .slot_o (slot_o)
   );

   irq_line_capture #(.LINE_W(LINE_W), .SEL_W(SEL_W)) u_cap (
      .clk         (clk),
      .rst         (rst),
      .lines_i     (req_lines_i),
      .slot_i      (slot_o),
      .cap_lines_o (cap_lines),
      .cap_grp_o   (cap_grp)
   );

   irq_pend_bank #(.LINE_W(LINE_W), .SEL_W(SEL_W)) u_bank (
      .clk         (clk),
      .rst         (rst),
      .mode_i      (scan_mode_i),
      .cap_lines_i (cap_lines),
      .cap_grp_i   (cap_grp),
      .raw_o       (raw)
   );

   always_comb begin
      pend_o          = raw;
      pend_o[AGG_BIT] = raw[AGG_BIT] | (|raw[LEVELS-1:LINE_W]);
   end

   AST_SUMMARY_BIT: assert property (@(posedge clk) disable iff (rst)
      (|pend_o[LEVELS-1:LINE_W]) |-> pend_o[AGG_BIT]);                     // R8
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (pend_o == '0 && slot_o == '0));                             // R1
endmodule

// File: tb/tb_irq_lvl_sync.sv
module tb_irq_lvl_sync;
   import irq_sync_pkg::*;

   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  scan_mode_i = 2'd0;
   logic [7:0]  req_lines_i = 8'd0;
   logic [1:0]  slot_o;
   logic [31:0] pend_o;

   int checks = 0;
   int fails  = 0;

   // model state
   logic [1:0]  m_mode;
   logic [1:0]  m_slot;
   logic [7:0]  m_cap;
   logic [1:0]  m_grp;
   logic [31:0] m_raw;

   irq_lvl_sync dut (
      .clk         (clk),
      .rst         (rst),
      .scan_mode_i (scan_mode_i),
      .req_lines_i (req_lines_i),
      .slot_o      (slot_o),
      .pend_o      (pend_o)
   );

   always #(PERIOD/2) clk = ~clk;

   // {mode, source pattern, cycles}
   localparam logic [41:0] VECS [0:7] = '{
      {2'd3, 32'hA5C3_3C81, 8'd10},
      {2'd3, 32'h0F0F_F0F0, 8'd9},
      {2'd2, 32'hFFFF_FFFF, 8'd8},
      {2'd1, 32'h1234_5678, 8'd7},
      {2'd0, 32'hDEAD_BE7F, 8'd5},
      {2'd3, 32'h8000_0001, 8'd9},
      {2'd1, 32'h00FF_FF00, 8'd6},
      {2'd2, 32'h0055_AA00, 8'd8}
   };

   function automatic logic [31:0] exp_pend();
      logic [31:0] e;
      e = m_raw;
      e[7] = m_raw[7] | (|m_raw[31:8]);
      return e;
   endfunction

   function automatic string slot_tag(input logic [1:0] md);
      case (md)
         2'd0:    return "R2";
         2'd1:    return "R3";
         2'd2:    return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_mode = 2'd0; m_slot = 2'd0; m_cap = 8'd0; m_grp = 2'd0; m_raw = 32'd0;
   endtask

   // Called at a negedge: drive for one cycle, advance the model, return at next negedge and check.
   task automatic cyc(input logic [1:0] md, input logic [31:0] src);
      logic [7:0] lines;
      lines = src[8*m_slot +: 8];
      scan_mode_i = md;
      req_lines_i = lines;
      @(posedge clk);
      for (int g = 0; g < 4; g++) begin
         if (2'(g) > md)        m_raw[8*g +: 8] = 8'd0;
         else if (m_grp == 2'(g)) m_raw[8*g +: 8] = m_cap;
      end
      m_cap = lines;
      m_grp = m_slot;
      if (md != m_mode || m_slot >= m_mode) m_slot = 2'd0;
      else                                  m_slot = m_slot + 2'd1;
      m_mode = md;
      @(negedge clk);
      chk({slot_tag(md), " slot"}, {30'd0, slot_o}, {30'd0, m_slot});
      chk("R6 pending", pend_o, exp_pend());
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      model_reset();
      @(negedge clk);
      chk("R1 pending", pend_o, 32'd0);
      chk("R1 slot", {30'd0, slot_o}, 32'd0);
      rst = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      model_reset();
      @(negedge clk);
      do_reset();

      // R7: latency of two edges from lines to pending
      cyc(SCAN_G0, 32'h0000_005A);
      chk("R7 not yet visible", pend_o, 32'd0);
      cyc(SCAN_G0, 32'h0000_005A);
      chk("R7 visible", pend_o, 32'h0000_005A);

      // R2: setting 0 keeps slot at 0 and upper groups clear
      for (int i = 0; i < 6; i++) begin
         cyc(SCAN_G0, 32'hFFFF_FFFF);
         chk("R2 slot held", {30'd0, slot_o}, 32'd0);
         chk("R2 upper clear", {8'd0, pend_o[31:8]}, 32'd0);
      end

      // R3 / R4 / R5: explicit slot sequences
      cyc(SCAN_G01, 32'd0);
      chk("R9 restart", {30'd0, slot_o}, 32'd0);
      for (int i = 0; i < 6; i++) begin
         cyc(SCAN_G01, 32'd0);
         chk("R3 sequence", {30'd0, slot_o}, 32'((i + 1) % 2));
      end
      cyc(SCAN_G012, 32'd0);
      for (int i = 0; i < 7; i++) begin
         cyc(SCAN_G012, 32'd0);
         chk("R4 sequence", {30'd0, slot_o}, 32'((i + 1) % 3));
      end
      cyc(SCAN_ALL, 32'd0);
      for (int i = 0; i < 9; i++) begin
         cyc(SCAN_ALL, 32'd0);
         chk("R5 sequence", {30'd0, slot_o}, 32'((i + 1) % 4));
      end

      // Table of patterns
      for (int v = 0; v < 8; v++) begin
         for (int n = 0; n < int'(VECS[v][7:0]); n++)
            cyc(VECS[v][41:40], VECS[v][39:8]);
      end

      // R6: every level captured in its own bit under full scan
      for (int i = 0; i < 8; i++) cyc(SCAN_ALL, 32'hC3A5_5A3C);
      chk("R6 full map", pend_o, 32'hC3A5_5ABC);

      // R8: only a top-group level with own bit 7 low
      for (int i = 0; i < 8; i++) cyc(SCAN_ALL, 32'h0100_0000);
      chk("R8 summary bit", pend_o, 32'h0100_0080);

      // R10: requests released clear pending
      for (int i = 0; i < 8; i++) cyc(SCAN_ALL, 32'd0);
      chk("R10 released", pend_o, 32'd0);

      // R9: shrink rotation while all levels requested
      for (int i = 0; i < 8; i++) cyc(SCAN_ALL, 32'hFFFF_FFFF);
      chk("R9 before change", pend_o, 32'hFFFF_FFFF);
      cyc(SCAN_G01, 32'hFFFF_FFFF);
      chk("R9 slot restart", {30'd0, slot_o}, 32'd0);
      chk("R9 upper cleared", {16'd0, pend_o[31:16]}, 32'd0);
      for (int i = 0; i < 4; i++) cyc(SCAN_G01, 32'hFFFF_FFFF);
      chk("R9 stays cleared", pend_o, 32'h0000_FFFF);

      // R1: reset in mid-operation
      do_reset();
      cyc(SCAN_ALL, 32'd0);
      chk("R1 after reset", pend_o, 32'd0);

      summary();
   end
endmodule